// File: doc/BRIEF.md
# Fork-Point Transaction ID Renamer

This block sits on one input port of a network router, at the point where requests from one master may split toward several destinations. It keeps a small table of the transaction IDs that still have requests in flight, and records for each ID the output port its latest request took. A request whose ID is already in flight but which leaves by a different output port is given a fresh sequence number. It is also marked incomplete, so that routers further along reserve reorder space for its return data. A request that repeats both the ID and the port of its entry, or that carries an ID with nothing in flight, passes through unchanged.

The block also keeps the original order of all outstanding requests. When the first flit of a returning data packet is seen, the block looks at the next request with the same ID in that order. If that request was renamed, a release packet naming its ID, sequence number and output port is sent at once, ahead of need, so that the data held downstream can start moving. Requests and release packets leave on one valid/ready control output, and a release always wins it. An incoming request is held (in_ready low) while a release is waiting, while the output is back-pressured, or while the table or the order queue has no room for it. The data-start notification uses its own valid/ready pair. Its ready is low while a release is waiting. The data-end notification is a plain pulse that retires the oldest outstanding request of its ID.

Top module: `fork_id_renamer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 with out_ready high. The table is empty, and the renaming counter holds 1.
- R2: A request whose ID has no outstanding request is forwarded with out_kind 0 (request), out_incomplete 0, out_seq 0, and out_rob_size equal to in_size. Its ID and port are passed through.
- R3: A request whose ID is active with the same output port as the ID's entry is forwarded unrenamed (out_incomplete 0, out_seq 0).
- R4: A request whose ID is active with a different output port is forwarded with out_incomplete 1, out_seq equal to the counter, and out_rob_size equal to in_size. The counter then advances by one, wrapping from all-ones to 1 so that 0 never names a renamed request. The ID's entry takes the new port.
- R5: An entry is freed when its last outstanding request is retired by resp_last. A later request with that ID is then treated as new (R2), whatever its port.
- R6: When all table entries are in use, a request with a new ID is held with in_ready low until an entry frees. A request with an ID that is already active is still accepted.
- R7: When resp_first is accepted, the oldest request of that ID that has not started is marked started. If the next request of that ID in original order was renamed, a release is presented on the output from the next cycle: out_kind 1, carrying that request's ID, sequence number and output port, with out_incomplete 0 and out_rob_size 0.
- R8: No release is issued when the next request of the ID was not renamed, or when there is none.
- R9: While a release is waiting, the output shows the release and in_ready is low, so no request is accepted until the release has been taken.
- R10: A renamed request whose same-ID predecessors have all started returning data causes a release for itself, presented from the cycle after the request is accepted.
- R11: With out_ready low, a waiting release holds out_valid and its fields stable, and resp_first_ready is low while a release waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request header valid |
| in_ready | output | 1 | Request header accepted this cycle when high with in_valid |
| in_id | input | ID_W | Transaction ID of the request |
| in_port | input | PORT_W | Computed output port of the request |
| in_size | input | SIZE_W | Size of the data packet the request returns |
| out_valid | output | 1 | Control packet valid |
| out_ready | input | 1 | Downstream accepts the control packet |
| out_kind | output | 1 | 0 = request header, 1 = release packet |
| out_id | output | ID_W | Transaction ID carried |
| out_port | output | PORT_W | Output port the packet is steered to |
| out_seq | output | SEQ_W | Sequence number (0 for unrenamed requests) |
| out_incomplete | output | 1 | Request needs reorder space reserved |
| out_rob_size | output | SIZE_W | Reorder space still needed by the request |
| resp_first_valid | input | 1 | First flit of a returning data packet seen |
| resp_first_ready | output | 1 | Data-start notification accepted |
| resp_first_id | input | ID_W | Transaction ID of that data packet |
| resp_last_valid | input | 1 | Last flit of a returning data packet seen |
| resp_last_id | input | ID_W | Transaction ID of that data packet |

## Verification
A wrong port in a table entry shows up on the very next request with that ID: its out_incomplete and out_seq flip in the same cycle it is accepted. A lost count or a missed free shows up as a request treated as renamed, or as new, after its last retire. It can also show up as in_ready staying low when the table should have room. An order-queue error (a wrong started flag or a wrong slot retired) shows up one cycle after resp_first: a release appears where none is due, or carries the wrong sequence number or port, or fails to appear at all. The directed sequences therefore check every returning data start for the presence and content of a release.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic {
    PKT_REQ = 1'b0,
    PKT_REL = 1'b1
  } pkt_kind_e;
endpackage

// File: rtl/fir_id_table.sv
module fir_id_table #(
  parameter int ID_W   = 4,
  parameter int PORT_W = 3,
  parameter int TBL_N  = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   lk_id,
  input  logic [PORT_W-1:0] lk_port,
  output logic              lk_hit,
  output logic              lk_port_diff,
  output logic              lk_room,
  input  logic              alloc_en,
  input  logic              dec_en,
  input  logic [ID_W-1:0]   dec_id
);
  localparam int TIDX_W = (TBL_N > 1) ? $clog2(TBL_N) : 1;

  logic [ID_W-1:0]   e_id   [TBL_N];
  logic [PORT_W-1:0] e_port [TBL_N];
  logic [CNT_W-1:0]  e_cnt  [TBL_N];

  logic [TBL_N-1:0]  hit_vec;
  logic [TBL_N-1:0]  dec_vec;
  logic [TIDX_W-1:0] free_idx;
  logic              free_any;

  always_comb begin
    lk_port_diff = 1'b0;
    free_any     = 1'b0;
    free_idx     = '0;
    for (int i = 0; i < TBL_N; i++) begin
      hit_vec[i] = (e_cnt[i] != '0) && (e_id[i] == lk_id);
      dec_vec[i] = (e_cnt[i] != '0) && (e_id[i] == dec_id);
      if (hit_vec[i] && (e_port[i] != lk_port)) lk_port_diff = 1'b1;
      if (!free_any && (e_cnt[i] == '0)) begin
        free_any = 1'b1;
        free_idx = TIDX_W'(i);
      end
    end
    lk_hit  = |hit_vec;
    lk_room = lk_hit || free_any;
  end

  for (genvar g = 0; g < TBL_N; g++) begin : g_ent
    logic inc, dec;
    assign inc = alloc_en && (lk_hit ? hit_vec[g] : (free_any && (free_idx == TIDX_W'(g))));
    assign dec = dec_en && dec_vec[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_cnt[g]  <= '0;
        e_id[g]   <= '0;
        e_port[g] <= '0;
      end else begin
        if (inc && !dec)      e_cnt[g] <= e_cnt[g] + 1'b1;
        else if (!inc && dec) e_cnt[g] <= e_cnt[g] - 1'b1;
        if (inc) begin
          e_id[g]   <= lk_id;
          e_port[g] <= lk_port;
        end
      end
    end
  end

  // R3
  id_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec));

  // R5
  retire_hits_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (|dec_vec));
endmodule

// File: rtl/fir_order_queue.sv
module fir_order_queue #(
  parameter int ID_W   = 4,
  parameter int PORT_W = 3,
  parameter int SEQ_W  = 4,
  parameter int Q_N    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PORT_W-1:0] push_port,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic              push_ren,
  output logic              full,
  input  logic [ID_W-1:0]   lk_id,
  output logic              lk_unstarted,
  input  logic              sop_en,
  input  logic [ID_W-1:0]   sop_id,
  output logic              rel_hit,
  output logic [ID_W-1:0]   rel_id,
  output logic [PORT_W-1:0] rel_port,
  output logic [SEQ_W-1:0]  rel_seq,
  input  logic              eop_en,
  input  logic [ID_W-1:0]   eop_id
);
  localparam int IDX_W = (Q_N > 1) ? $clog2(Q_N) : 1;
  localparam int CW    = $clog2(Q_N + 1);

  logic [ID_W-1:0]   q_id   [Q_N];
  logic [PORT_W-1:0] q_port [Q_N];
  logic [SEQ_W-1:0]  q_seq  [Q_N];
  logic              q_ren  [Q_N];
  logic              q_st   [Q_N];
  logic [CW-1:0]     q_cnt;

  logic [ID_W-1:0]   n_id   [Q_N];
  logic [PORT_W-1:0] n_port [Q_N];
  logic [SEQ_W-1:0]  n_seq  [Q_N];
  logic              n_ren  [Q_N];
  logic              n_st   [Q_N];
  logic              a_st   [Q_N];
  logic [CW-1:0]     n_cnt;
  logic [CW-1:0]     mid_cnt;

  logic              s_found, n_found, e_found;
  logic [IDX_W-1:0]  s_idx, n_idx, e_idx;

  assign full = (q_cnt == CW'(Q_N));

  // lookups on current state
  always_comb begin
    s_found = 1'b0; s_idx = '0;
    n_found = 1'b0; n_idx = '0;
    e_found = 1'b0; e_idx = '0;
    lk_unstarted = 1'b0;
    for (int i = 0; i < Q_N; i++) begin
      if (i < int'(q_cnt)) begin
        if (!s_found && (q_id[i] == sop_id) && !q_st[i]) begin
          s_found = 1'b1;
          s_idx   = IDX_W'(i);
        end
        if (!e_found && (q_id[i] == eop_id)) begin
          e_found = 1'b1;
          e_idx   = IDX_W'(i);
        end
        if ((q_id[i] == lk_id) && !q_st[i]) lk_unstarted = 1'b1;
      end
    end
    for (int i = 0; i < Q_N; i++) begin
      if (!n_found && s_found && (i > int'(s_idx)) && (i < int'(q_cnt)) && (q_id[i] == sop_id)) begin
        n_found = 1'b1;
        n_idx   = IDX_W'(i);
      end
    end
    rel_hit  = sop_en && s_found && n_found && q_ren[n_idx];
    rel_id   = q_id[n_idx];
    rel_port = q_port[n_idx];
    rel_seq  = q_seq[n_idx];
  end

  // next state: mark started, remove retired slot, append at tail
  always_comb begin
    for (int i = 0; i < Q_N; i++) begin
      a_st[i] = q_st[i] || (sop_en && s_found && (i == int'(s_idx)));
    end
    mid_cnt = (eop_en && e_found) ? (q_cnt - 1'b1) : q_cnt;
    for (int i = 0; i < Q_N; i++) begin
      if (eop_en && e_found && (i >= int'(e_idx)) && (i < Q_N - 1)) begin
        n_id[i]   = q_id[i+1];
        n_port[i] = q_port[i+1];
        n_seq[i]  = q_seq[i+1];
        n_ren[i]  = q_ren[i+1];
        n_st[i]   = a_st[i+1];
      end else begin
        n_id[i]   = q_id[i];
        n_port[i] = q_port[i];
        n_seq[i]  = q_seq[i];
        n_ren[i]  = q_ren[i];
        n_st[i]   = a_st[i];
      end
      if (push_en && (i == int'(mid_cnt))) begin
        n_id[i]   = push_id;
        n_port[i] = push_port;
        n_seq[i]  = push_seq;
        n_ren[i]  = push_ren;
        n_st[i]   = 1'b0;
      end
    end
    n_cnt = push_en ? (mid_cnt + 1'b1) : mid_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt <= '0;
      for (int i = 0; i < Q_N; i++) begin
        q_id[i]   <= '0;
        q_port[i] <= '0;
        q_seq[i]  <= '0;
        q_ren[i]  <= 1'b0;
        q_st[i]   <= 1'b0;
      end
    end else begin
      q_cnt  <= n_cnt;
      q_id   <= n_id;
      q_port <= n_port;
      q_seq  <= n_seq;
      q_ren  <= n_ren;
      q_st   <= n_st;
    end
  end

  // R6
  no_queue_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full);

  // R5
  retire_in_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_en |-> e_found);
endmodule

// File: rtl/fir_rel_arbiter.sv
module fir_rel_arbiter
  import fir_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int PORT_W = 3,
  parameter int SEQ_W  = 4,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rel_load,
  input  logic [ID_W-1:0]   rel_id_in,
  input  logic [PORT_W-1:0] rel_port_in,
  input  logic [SEQ_W-1:0]  rel_seq_in,
  output logic              rel_busy,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [PORT_W-1:0] req_port,
  input  logic [SEQ_W-1:0]  req_seq,
  input  logic              req_incomplete,
  input  logic [SIZE_W-1:0] req_rob_size,
  output logic              out_valid,
  input  logic              out_ready,
  output pkt_kind_e         out_kind,
  output logic [ID_W-1:0]   out_id,
  output logic [PORT_W-1:0] out_port,
  output logic [SEQ_W-1:0]  out_seq,
  output logic              out_incomplete,
  output logic [SIZE_W-1:0] out_rob_size
);
  logic              h_full;
  logic [ID_W-1:0]   h_id;
  logic [PORT_W-1:0] h_port;
  logic [SEQ_W-1:0]  h_seq;

  assign rel_busy = h_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_full <= 1'b0;
      h_id   <= '0;
      h_port <= '0;
      h_seq  <= '0;
    end else if (rel_load) begin
      h_full <= 1'b1;
      h_id   <= rel_id_in;
      h_port <= rel_port_in;
      h_seq  <= rel_seq_in;
    end else if (h_full && out_ready) begin
      h_full <= 1'b0;
    end
  end

  always_comb begin
    out_valid = h_full || req_valid;
    if (h_full) begin
      out_kind       = PKT_REL;
      out_id         = h_id;
      out_port       = h_port;
      out_seq        = h_seq;
      out_incomplete = 1'b0;
      out_rob_size   = '0;
    end else begin
      out_kind       = PKT_REQ;
      out_id         = req_id;
      out_port       = req_port;
      out_seq        = req_seq;
      out_incomplete = req_incomplete;
      out_rob_size   = req_rob_size;
    end
  end

  // R11
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == PKT_REL) && !out_ready) |=>
      (out_valid && (out_kind == PKT_REL) && $stable(out_id) && $stable(out_seq) && $stable(out_port)));

  // R9
  no_double_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_load |-> !h_full);
endmodule

// File: rtl/fork_id_renamer.sv
module fork_id_renamer
  import fir_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int PORT_W = 3,
  parameter int SIZE_W = 4,
  parameter int SEQ_W  = 4,
  parameter int TBL_N  = 8,
  parameter int Q_N    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ID_W-1:0]   in_id,
  input  logic [PORT_W-1:0] in_port,
  input  logic [SIZE_W-1:0] in_size,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_kind,
  output logic [ID_W-1:0]   out_id,
  output logic [PORT_W-1:0] out_port,
  output logic [SEQ_W-1:0]  out_seq,
  output logic              out_incomplete,
  output logic [SIZE_W-1:0] out_rob_size,
  input  logic              resp_first_valid,
  output logic              resp_first_ready,
  input  logic [ID_W-1:0]   resp_first_id,
  input  logic              resp_last_valid,
  input  logic [ID_W-1:0]   resp_last_id
);
  localparam int CNT_W = $clog2(Q_N + 1);

  logic              t_hit, t_diff, t_room;
  logic              q_full, q_unstarted;
  logic              q_rel_hit;
  logic [ID_W-1:0]   q_rel_id;
  logic [PORT_W-1:0] q_rel_port;
  logic [SEQ_W-1:0]  q_rel_seq;
  logic              rel_busy;
  logic [SEQ_W-1:0]  seq_q;
  pkt_kind_e         kind_e;

  logic renamed, late_rel, can_take, in_fire, first_fire, rel_load;
  logic [SEQ_W-1:0]  req_seq;
  logic [ID_W-1:0]   rel_id_mux;
  logic [PORT_W-1:0] rel_port_mux;
  logic [SEQ_W-1:0]  rel_seq_mux;

  assign renamed  = t_hit && t_diff;
  assign late_rel = renamed && !q_unstarted;
  assign req_seq  = renamed ? seq_q : '0;

  // hold a request when: no room, a same-ID data start is being taken,
  // or its own late release would collide with a data-start release
  assign can_take = t_room && !q_full
                 && !(resp_first_valid && (resp_first_id == in_id))
                 && !(late_rel && resp_first_valid);

  assign in_ready         = out_ready && !rel_busy && can_take;
  assign in_fire          = in_valid && in_ready;
  assign resp_first_ready = !rel_busy;
  assign first_fire       = resp_first_valid && resp_first_ready;

  assign rel_load     = (first_fire && q_rel_hit) || (in_fire && late_rel);
  assign rel_id_mux   = (in_fire && late_rel) ? in_id   : q_rel_id;
  assign rel_port_mux = (in_fire && late_rel) ? in_port : q_rel_port;
  assign rel_seq_mux  = (in_fire && late_rel) ? seq_q   : q_rel_seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= SEQ_W'(1);
    end else if (in_fire && renamed) begin
      seq_q <= (seq_q == {SEQ_W{1'b1}}) ? SEQ_W'(1) : (seq_q + 1'b1);
    end
  end

  fir_id_table #(
    .ID_W(ID_W), .PORT_W(PORT_W), .TBL_N(TBL_N), .CNT_W(CNT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .lk_id(in_id), .lk_port(in_port),
    .lk_hit(t_hit), .lk_port_diff(t_diff), .lk_room(t_room),
    .alloc_en(in_fire),
    .dec_en(resp_last_valid), .dec_id(resp_last_id)
  );

  fir_order_queue #(
    .ID_W(ID_W), .PORT_W(PORT_W), .SEQ_W(SEQ_W), .Q_N(Q_N)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push_en(in_fire), .push_id(in_id), .push_port(in_port),
    .push_seq(req_seq), .push_ren(renamed),
    .full(q_full),
    .lk_id(in_id), .lk_unstarted(q_unstarted),
    .sop_en(first_fire), .sop_id(resp_first_id),
    .rel_hit(q_rel_hit), .rel_id(q_rel_id), .rel_port(q_rel_port), .rel_seq(q_rel_seq),
    .eop_en(resp_last_valid), .eop_id(resp_last_id)
  );

  fir_rel_arbiter #(
    .ID_W(ID_W), .PORT_W(PORT_W), .SEQ_W(SEQ_W), .SIZE_W(SIZE_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .rel_load(rel_load), .rel_id_in(rel_id_mux), .rel_port_in(rel_port_mux),
    .rel_seq_in(rel_seq_mux), .rel_busy(rel_busy),
    .req_valid(in_valid && can_take),
    .req_id(in_id), .req_port(in_port), .req_seq(req_seq),
    .req_incomplete(renamed), .req_rob_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(kind_e),
    .out_id(out_id), .out_port(out_port), .out_seq(out_seq),
    .out_incomplete(out_incomplete), .out_rob_size(out_rob_size)
  );

  assign out_kind = kind_e;

  // R4
  renamed_seq_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && out_incomplete) |-> (out_seq != '0));

  // R9
  req_not_over_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (kind_e == PKT_REQ));

  // R10
  late_rel_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && late_rel) |=> (out_valid && (kind_e == PKT_REL) && (out_seq == $past(seq_q))));
endmodule

// File: tb/fork_id_renamer_tb.sv
module fork_id_renamer_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready;
  logic [3:0] in_id;
  logic [2:0] in_port;
  logic [3:0] in_size;
  logic       out_valid, out_ready, out_kind, out_incomplete;
  logic [3:0] out_id, out_seq, out_rob_size;
  logic [2:0] out_port;
  logic       rf_valid, rf_ready, rl_valid;
  logic [3:0] rf_id, rl_id;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic       c_kind, c_inc;
  logic [3:0] c_id, c_seq, c_rob;
  logic [2:0] c_port;

  always #5 clk = ~clk;

  fork_id_renamer u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id), .in_port(in_port), .in_size(in_size),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind), .out_id(out_id),
    .out_port(out_port), .out_seq(out_seq), .out_incomplete(out_incomplete), .out_rob_size(out_rob_size),
    .resp_first_valid(rf_valid), .resp_first_ready(rf_ready), .resp_first_id(rf_id),
    .resp_last_valid(rl_valid), .resp_last_id(rl_id)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [3:0] id, input logic [2:0] port, input logic [3:0] size);
    @(negedge clk);
    in_valid = 1'b1; in_id = id; in_port = port; in_size = size;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    c_kind = out_kind; c_inc = out_incomplete; c_id = out_id;
    c_seq = out_seq; c_rob = out_rob_size; c_port = out_port;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic first(input logic [3:0] id);
    @(negedge clk);
    rf_valid = 1'b1; rf_id = id;
    #1;
    while (!rf_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    rf_valid = 1'b0;
    #1;
  endtask

  task automatic last(input logic [3:0] id);
    @(negedge clk);
    rl_valid = 1'b1; rl_id = id;
    @(posedge clk); #1;
    rl_valid = 1'b0;
  endtask

  task automatic expect_rel(input string req, input int id, input int seq, input int port);
    check(req, "release valid", int'(out_valid), 1);
    check(req, "release kind", int'(out_kind), 1);
    check(req, "release id", int'(out_id), id);
    check(req, "release seq", int'(out_seq), seq);
    check(req, "release port", int'(out_port), port);
  endtask

  task automatic t_reset();
    // R1
    #1;
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_rename();
    send_req(4'd1, 3'd2, 4'd5);               // R2
    check("R2", "kind", int'(c_kind), 0);
    check("R2", "incomplete", int'(c_inc), 0);
    check("R2", "seq", int'(c_seq), 0);
    check("R2", "rob_size", int'(c_rob), 5);
    check("R2", "id", int'(c_id), 1);
    check("R2", "port", int'(c_port), 2);
    send_req(4'd1, 3'd2, 4'd5);               // R3
    check("R3", "incomplete same port", int'(c_inc), 0);
    check("R3", "seq same port", int'(c_seq), 0);
    send_req(4'd1, 3'd4, 4'd6);               // R4
    check("R4", "incomplete new port", int'(c_inc), 1);
    check("R4", "seq first rename", int'(c_seq), 1);
    check("R4", "rob_size renamed", int'(c_rob), 6);
    send_req(4'd1, 3'd4, 4'd6);               // R3: entry now holds port 4
    check("R3", "incomplete updated port", int'(c_inc), 0);
    send_req(4'd1, 3'd2, 4'd7);               // R4
    check("R4", "incomplete back to old port", int'(c_inc), 1);
    check("R4", "seq second rename", int'(c_seq), 2);
  endtask

  task automatic t_release();
    // queue id1: A p2, B p2, C p4 seq1 renamed, D p4, E p2 seq2 renamed
    first(4'd1);                              // R8: next is B, not renamed
    check("R8", "no release after A start", int'(out_valid), 0);
    last(4'd1);
    first(4'd1);                              // R7: next is C, renamed
    out_ready = 1'b0;
    in_valid = 1'b1; in_id = 4'd2; in_port = 3'd0; in_size = 4'd1;
    #1;
    expect_rel("R7", 1, 1, 4);
    check("R9", "in_ready while release waits", int'(in_ready), 0);
    check("R11", "resp_first_ready while release waits", int'(rf_ready), 0);
    @(negedge clk); #1;
    check("R11", "release held kind", int'(out_kind), 1);
    check("R11", "release held seq", int'(out_seq), 1);
    check("R11", "release held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    #1;
    check("R9", "output idle after release taken", int'(out_valid), 0);
    last(4'd1);
    first(4'd1);                              // R8: next is D, not renamed
    check("R8", "no release after C start", int'(out_valid), 0);
    last(4'd1);
    first(4'd1);                              // R7: next is E, renamed
    expect_rel("R7", 1, 2, 2);
    last(4'd1);
    first(4'd1);                              // R8: no next
    check("R8", "no release after last start", int'(out_valid), 0);
    last(4'd1);
  endtask

  task automatic t_free();
    send_req(4'd1, 3'd5, 4'd3);               // R5
    check("R5", "freed id not renamed", int'(c_inc), 0);
    check("R5", "freed id seq", int'(c_seq), 0);
    last(4'd1);
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++) send_req(4'(k), 3'd0, 4'd2);
    @(negedge clk);
    in_valid = 1'b1; in_id = 4'd9; in_port = 3'd0; in_size = 4'd2;
    #1;
    check("R6", "new id held when table full", int'(in_ready), 0);
    @(negedge clk); #1;
    check("R6", "new id still held", int'(in_ready), 0);
    in_valid = 1'b0;
    send_req(4'd3, 3'd0, 4'd2);               // R6: active id accepted
    check("R6", "active id accepted when full", int'(c_inc), 0);
    @(negedge clk);
    in_valid = 1'b1; in_id = 4'd9; rl_valid = 1'b1; rl_id = 4'd0;
    #1;
    check("R6", "held in the freeing cycle", int'(in_ready), 0);
    @(posedge clk); #1;
    rl_valid = 1'b0;
    in_valid = 1'b0;
    send_req(4'd9, 3'd0, 4'd2);
    check("R6", "new id accepted after free", int'(c_id), 9);
    for (int k = 1; k < 8; k++) last(4'(k));
    last(4'd3);
    last(4'd9);
  endtask

  task automatic t_late();
    send_req(4'd6, 3'd1, 4'd4);
    first(4'd6);                              // R8: no next yet
    check("R8", "no release with no successor", int'(out_valid), 0);
    send_req(4'd6, 3'd3, 4'd4);               // R10
    check("R10", "late request renamed", int'(c_inc), 1);
    check("R10", "late request seq", int'(c_seq), 3);
    expect_rel("R10", 6, 3, 3);
    @(posedge clk); #1;
    check("R10", "late release consumed", int'(out_valid), 0);
    last(4'd6);
    last(4'd6);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_id = '0; in_port = '0; in_size = '0;
    out_ready = 1'b1; rf_valid = 1'b0; rf_id = '0; rl_valid = 1'b0; rl_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rename();
    t_release();
    t_free();
    t_full();
    t_late();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule